// File: doc/BRIEF.md
# Multi-Mode Pixel Serializer with Pen Palette

This block turns one fetched video byte into a group of coloured pixels. Each byte is split into two, four or eight pen indices according to the active screen mode. Each index picks one of sixteen pen entries, and a seventeenth entry serves as the border. Each entry holds a 5-bit hardware colour code, which is mapped to an 8-bit RGB332 value. A free-running four-phase sequencer samples the byte, the display-enable flag and the horizontal sync once every four clocks. On each such sample the whole pixel group is registered onto a parallel output, together with its pixel count.

Software reaches the block through an I/O write strobe with a 16-bit address and an 8-bit data word. The top two data bits choose the function: pen select, pen colour, or mode/ROM control. A new screen mode is held pending and only takes effect once the horizontal sync, as seen by the sequencer, drops. The same control write also sets the upper-ROM enable level and can issue a one-clock pulse that clears an external interrupt counter.

The phase sequencer steps PH_A to PH_B to PH_C to PH_D and back to PH_A, one step per clock; the tick is PH_D. The mode deferral machine has two states. ARM_IDLE moves to ARM_WAIT on any mode/ROM control write. ARM_WAIT stays in ARM_WAIT on a further control write, which replaces the pending mode. ARM_WAIT returns to ARM_IDLE when a tick sees sync low after the previous tick saw it high; on that transition the pending mode is applied.

Top module: `pixser_top`

## Requirements
- R1: While reset is asserted, and until the first tick after it, pix_vld, pix_cnt, pix_rgb and irq_cnt_clr are 0 and upper_rom_en is 1. Reset also sets all pen entries to code 0, the selected pen to 0 and the mode to 0.
- R2: The tick falls on the 4th rising edge after reset release and then on every 4th edge. pix_vld is 1 for exactly the one clock after each tick edge. pix_cnt and pix_rgb keep their values between ticks.
- R3: A write is accepted only when io_wr is 1 and io_addr[15] is 0. The state of io_addr[14] makes no difference. With io_addr[15] at 1 the write has no effect.
- R4: Function is io_data[7:6]. With 00, the selected pen becomes 16 (the border) if io_data[4] is 1, and io_data[3:0] otherwise. With 01, io_data[4:0] is written into the selected pen entry. Code 11 has no effect.
- R5: Modes 0 and 3 give 2 pixels. Pixel n (n = 0, 1) is made of byte bits 7-n, 3-n, 5-n and 1-n, which supply its index bits 0, 1, 2 and 3 in that order.
- R6: Mode 1 gives 4 pixels. Pixel n takes byte bit 7-n as index bit 0 and byte bit 3-n as index bit 1.
- R7: Mode 2 gives 8 one-bit pixels; pixel n is byte bit 7-n.
- R8: A colour code c is first reduced to c-27 if it is 27 or more. The reduced value gives levels r=c/9, g=(c/3)%3 and b=c%3. The output is {R3,G3,B2}, where R3 and G3 are 000, 100 or 111 and B2 is 00, 10 or 11 for levels 0, 1 and 2.
- R9: When disp_en is 0 at a tick, every produced pixel takes the border entry's colour.
- R10: A control write (function 10) stores io_data[1:0] as the pending mode. The pending mode is applied at the first tick that sees hsync 0 after the previous tick saw it 1. A later control write before that replaces the pending value. A tick decodes its byte with the mode in force before that tick.
- R11: A control write drives upper_rom_en to the inverse of io_data[3] from the next clock. If io_data[4] is 1, irq_cnt_clr is 1 for exactly that next clock.
- R12: pix_cnt is 2, 4 or 8 by mode. Pixel n occupies pix_rgb[8n+7:8n], and slots at or above pix_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address; bit 15 low selects this block |
| io_data | input | 8 | I/O write data |
| vid_byte | input | 8 | Fetched video byte, sampled at the tick |
| disp_en | input | 1 | Display enable, sampled at the tick |
| hsync | input | 1 | Horizontal sync, sampled at the tick |
| pix_vld | output | 1 | One-clock pulse marking a new pixel group |
| pix_cnt | output | 4 | Number of pixels in the group (2, 4 or 8) |
| pix_rgb | output | 64 | Pixel colours, RGB332, pixel n in bits 8n+7:8n |
| upper_rom_en | output | 1 | Upper ROM enable level |
| irq_cnt_clr | output | 1 | One-clock pulse clearing the interrupt counter |

## Verification
A pixel group is due one clock after the tick edge, so it first appears after the 4th edge following reset release. Register writes show on upper_rom_en and irq_cnt_clr one clock after the write edge. A pen entry change affects the next tick that reads that entry. A mode write affects only the first tick after the tick that saw hsync fall. The bench steps a behavioural model on every rising edge, using the same input values as the design. It compares every output against the model at each falling edge, which lands each check in the cycle where that result is due. The stimulus shows pen colour and selection only through pixel output, and it times hsync pulses around pending mode writes.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        VM_WIDE = 2'd0,
        VM_MID  = 2'd1,
        VM_FINE = 2'd2,
        VM_ALT  = 2'd3
    } vmode_e;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2,
        PH_D = 2'd3
    } phase_e;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_e;

    typedef enum logic [1:0] {
        FN_PEN = 2'd0,
        FN_COL = 2'd1,
        FN_CTL = 2'd2,
        FN_NOP = 2'd3
    } func_e;

    function automatic logic [2:0] level3(input logic [1:0] lv);
        unique case (lv)
            2'd0:    return 3'b000;
            2'd1:    return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [1:0] level2(input logic [1:0] lv);
        unique case (lv)
            2'd0:    return 2'b00;
            2'd1:    return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [7:0] hwc_to_rgb332(input logic [4:0] code);
        logic [4:0] c;
        logic [1:0] r;
        logic [1:0] g;
        logic [1:0] b;
        c = (code >= 5'd27) ? (code - 5'd27) : code;
        r = 2'(c / 5'd9);
        g = 2'((c / 5'd3) % 5'd3);
        b = 2'(c % 5'd3);
        return {level3(r), level3(g), level2(b)};
    endfunction

endpackage

// File: rtl/pixser_ctrl.sv
module pixser_ctrl
    import pixser_pkg::*;
#(
    parameter int NPENS = 16,
    parameter int HWC_W = 5,
    localparam int SEL_W = $clog2(NPENS + 1),
    localparam int TAB_W = (NPENS + 1) * HWC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hsync,
    input  logic             io_wr,
    input  logic [15:0]      io_addr,
    input  logic [7:0]       io_data,
    output vmode_e           mode,
    output logic [TAB_W-1:0] pen_tab,
    output logic             upper_rom_en,
    output logic             irq_cnt_clr
);

    logic       sel_hit;
    func_e      fn;
    logic       wr_pen;
    logic       wr_col;
    logic       wr_ctl;
    logic       hs_q;
    logic       fall;
    arm_e       arm_q;
    arm_e       arm_d;
    vmode_e     mode_q;
    vmode_e     pend_q;
    logic [SEL_W-1:0] pen_sel;
    logic       unused_ctl_bits;

    assign unused_ctl_bits = ^{io_addr[14:0], io_data[5]};

    assign sel_hit = io_wr & ~io_addr[15];
    assign fn      = func_e'(io_data[7:6]);
    assign wr_pen  = sel_hit && (fn == FN_PEN);
    assign wr_col  = sel_hit && (fn == FN_COL);
    assign wr_ctl  = sel_hit && (fn == FN_CTL);
    assign fall    = tick & hs_q & ~hsync;

    // pen selection register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_sel <= '0;
        end else if (wr_pen) begin
            pen_sel <= io_data[4] ? SEL_W'(NPENS) : SEL_W'(io_data[3:0]);
        end
    end

    // pen table, one register per entry (last entry is the border)
    for (genvar g = 0; g <= NPENS; g++) begin : g_pen
        logic [HWC_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (wr_col && (pen_sel == SEL_W'(g))) begin
                ent_q <= io_data[HWC_W-1:0];
            end
        end
        assign pen_tab[g*HWC_W +: HWC_W] = ent_q;
    end

    // mode deferral machine: next state
    always_comb begin
        unique case (arm_q)
            ARM_IDLE: arm_d = wr_ctl ? ARM_WAIT : ARM_IDLE;
            ARM_WAIT: arm_d = wr_ctl ? ARM_WAIT : (fall ? ARM_IDLE : ARM_WAIT);
        endcase
    end

    // mode deferral machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_IDLE;
        end else begin
            arm_q <= arm_d;
        end
    end

    // mode deferral machine: data and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q         <= 1'b0;
            mode_q       <= VM_WIDE;
            pend_q       <= VM_WIDE;
            upper_rom_en <= 1'b1;
            irq_cnt_clr  <= 1'b0;
        end else begin
            if (tick) begin
                hs_q <= hsync;
            end
            if ((arm_q == ARM_WAIT) && fall) begin
                mode_q <= pend_q;
            end
            if (wr_ctl) begin
                pend_q       <= vmode_e'(io_data[1:0]);
                upper_rom_en <= ~io_data[3];
            end
            irq_cnt_clr <= wr_ctl & io_data[4];
        end
    end

    assign mode = mode_q;

    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[15]) |=> ($stable(pen_sel) && $stable(pend_q) && $stable(upper_rom_en))); // R3

    AST_MODE_AT_HS_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(tick && hs_q && !hsync)); // R10

    AST_ROM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_addr[15] && io_data[7:6] == 2'b10) |=> (upper_rom_en == !$past(io_data[3]))); // R11

endmodule

// File: rtl/pixser_unpack.sv
module pixser_unpack
    import pixser_pkg::*;
#(
    parameter int MAX_PIX = 8,
    parameter int IDX_W   = 4,
    localparam int CNT_W  = $clog2(MAX_PIX + 1)
) (
    input  logic [BYTE_W-1:0]        vbyte,
    input  vmode_e                   mode,
    output logic [MAX_PIX*IDX_W-1:0] idx,
    output logic [CNT_W-1:0]         cnt,
    output logic [MAX_PIX-1:0]       act
);

    always_comb begin
        unique case (mode)
            VM_WIDE, VM_ALT: cnt = CNT_W'(2);
            VM_MID:          cnt = CNT_W'(4);
            VM_FINE:         cnt = CNT_W'(8);
        endcase
    end

    for (genvar k = 0; k < MAX_PIX; k++) begin : g_slot
        logic [IDX_W-1:0] w_idx;
        logic [IDX_W-1:0] m_idx;
        logic [IDX_W-1:0] f_idx;
        logic [IDX_W-1:0] sel_idx;

        if (k < 2) begin : g_wide
            assign w_idx = IDX_W'({vbyte[1-k], vbyte[5-k], vbyte[3-k], vbyte[7-k]});
        end else begin : g_wide_off
            assign w_idx = '0;
        end

        if (k < 4) begin : g_mid
            assign m_idx = IDX_W'({vbyte[3-k], vbyte[7-k]});
        end else begin : g_mid_off
            assign m_idx = '0;
        end

        assign f_idx = IDX_W'(vbyte[7-k]);

        always_comb begin
            unique case (mode)
                VM_WIDE, VM_ALT: sel_idx = w_idx;
                VM_MID:          sel_idx = m_idx;
                VM_FINE:         sel_idx = f_idx;
            endcase
        end

        assign idx[k*IDX_W +: IDX_W] = sel_idx;
        assign act[k] = (CNT_W'(k) < cnt);
    end

endmodule

// File: rtl/pixser_palette.sv
module pixser_palette
    import pixser_pkg::*;
#(
    parameter int MAX_PIX = 8,
    parameter int IDX_W   = 4,
    parameter int NPENS   = 16,
    parameter int HWC_W   = 5,
    localparam int TAB_W  = (NPENS + 1) * HWC_W
) (
    input  logic [MAX_PIX*IDX_W-1:0] idx,
    input  logic [MAX_PIX-1:0]       act,
    input  logic [TAB_W-1:0]         pen_tab,
    input  logic                     border,
    output logic [MAX_PIX*8-1:0]     rgb
);

    for (genvar k = 0; k < MAX_PIX; k++) begin : g_lut
        logic [IDX_W-1:0] pen;
        logic [HWC_W-1:0] code;

        assign pen  = idx[k*IDX_W +: IDX_W];
        assign code = border ? pen_tab[NPENS*HWC_W +: HWC_W]
                             : pen_tab[int'(pen)*HWC_W +: HWC_W];
        assign rgb[k*8 +: 8] = act[k] ? hwc_to_rgb332(code) : 8'h00;
    end

endmodule

// File: rtl/pixser_top.sv
module pixser_top
    import pixser_pkg::*;
#(
    parameter int MAX_PIX = 8,
    parameter int NPENS   = 16,
    parameter int HWC_W   = 5,
    localparam int IDX_W  = $clog2(NPENS),
    localparam int CNT_W  = $clog2(MAX_PIX + 1),
    localparam int TAB_W  = (NPENS + 1) * HWC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic [15:0]          io_addr,
    input  logic [7:0]           io_data,
    input  logic [7:0]           vid_byte,
    input  logic                 disp_en,
    input  logic                 hsync,
    output logic                 pix_vld,
    output logic [CNT_W-1:0]     pix_cnt,
    output logic [MAX_PIX*8-1:0] pix_rgb,
    output logic                 upper_rom_en,
    output logic                 irq_cnt_clr
);

    phase_e                   ph_q;
    phase_e                   ph_d;
    logic                     tick;
    vmode_e                   mode;
    logic [TAB_W-1:0]         pen_tab;
    logic [MAX_PIX*IDX_W-1:0] idx;
    logic [CNT_W-1:0]         grp_cnt;
    logic [MAX_PIX-1:0]       act;
    logic [MAX_PIX*8-1:0]     grp_rgb;

    // phase sequencer: next state
    always_comb begin
        unique case (ph_q)
            PH_A: ph_d = PH_B;
            PH_B: ph_d = PH_C;
            PH_C: ph_d = PH_D;
            PH_D: ph_d = PH_A;
        endcase
    end

    // phase sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_A;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign tick = (ph_q == PH_D);

    pixser_ctrl #(
        .NPENS (NPENS),
        .HWC_W (HWC_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .hsync        (hsync),
        .io_wr        (io_wr),
        .io_addr      (io_addr),
        .io_data      (io_data),
        .mode         (mode),
        .pen_tab      (pen_tab),
        .upper_rom_en (upper_rom_en),
        .irq_cnt_clr  (irq_cnt_clr)
    );

    pixser_unpack #(
        .MAX_PIX (MAX_PIX),
        .IDX_W   (IDX_W)
    ) u_unpack (
        .vbyte (vid_byte),
        .mode  (mode),
        .idx   (idx),
        .cnt   (grp_cnt),
        .act   (act)
    );

    pixser_palette #(
        .MAX_PIX (MAX_PIX),
        .IDX_W   (IDX_W),
        .NPENS   (NPENS),
        .HWC_W   (HWC_W)
    ) u_palette (
        .idx     (idx),
        .act     (act),
        .pen_tab (pen_tab),
        .border  (~disp_en),
        .rgb     (grp_rgb)
    );

    // output registers, loaded on the tick edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_vld <= 1'b0;
            pix_cnt <= '0;
            pix_rgb <= '0;
        end else if (tick) begin
            pix_vld <= 1'b1;
            pix_cnt <= grp_cnt;
            pix_rgb <= grp_rgb;
        end else begin
            pix_vld <= 1'b0;
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> !pix_vld); // R2

    AST_CNT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> ($countones(pix_cnt) == 1)); // R12

    AST_UNUSED_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_cnt == CNT_W'(2)) |-> (pix_rgb[MAX_PIX*8-1:16] == '0)); // R12

endmodule

// File: tb/tb_pixser_top.sv
module tb_pixser_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr;
    logic [15:0] io_addr;
    logic [7:0]  io_data;
    logic [7:0]  vid_byte;
    logic        disp_en;
    logic        hsync;
    logic        pix_vld;
    logic [3:0]  pix_cnt;
    logic [63:0] pix_rgb;
    logic        upper_rom_en;
    logic        irq_cnt_clr;

    always #2 clk = ~clk;

    pixser_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_wr        (io_wr),
        .io_addr      (io_addr),
        .io_data      (io_data),
        .vid_byte     (vid_byte),
        .disp_en      (disp_en),
        .hsync        (hsync),
        .pix_vld      (pix_vld),
        .pix_cnt      (pix_cnt),
        .pix_rgb      (pix_rgb),
        .upper_rom_en (upper_rom_en),
        .irq_cnt_clr  (irq_cnt_clr)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 0;
    int    vb_state = 17;

    // behavioural reference state
    int          m_ph = 0, m_mode = 0, m_pend = 0, m_sel = 0;
    bit          m_armed = 0, m_hsq = 0;
    int          m_tab[17];
    bit          e_vld = 0, e_irq = 0, e_rom = 1;
    int          e_cnt = 0;
    logic [63:0] e_rgb = '0;
    bit          t_tick, t_fall, t_ctl;
    int          t_code;

    function automatic int col332(int code);
        int c;
        int lv[3] = '{0, 128, 255};
        c = code % 32;
        if (c >= 27) c = c - 27;
        return ((lv[c / 9] >> 5) << 5) | ((lv[(c / 3) % 3] >> 5) << 2) | (lv[c % 3] >> 6);
    endfunction

    function automatic int pix_count(int mode);
        if (mode == 1) return 4;
        if (mode == 2) return 8;
        return 2;
    endfunction

    function automatic int pen_of(int mode, int bv, int n);
        int pos[2][4] = '{'{7, 3, 5, 1}, '{6, 2, 4, 0}};
        int v = 0;
        if (mode == 1) return ((bv >> (7 - n)) & 1) | (((bv >> (3 - n)) & 1) << 1);
        if (mode == 2) return (bv >> (7 - n)) & 1;
        for (int k = 0; k < 4; k++) v = v | (((bv >> pos[n][k]) & 1) << k);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_pend = 0; m_sel = 0; m_armed = 0; m_hsq = 0;
            for (int i = 0; i < 17; i++) m_tab[i] = 0;
            e_vld = 0; e_irq = 0; e_rom = 1; e_cnt = 0; e_rgb = '0;
        end else begin
            t_tick = (m_ph == 3);
            t_fall = t_tick && m_hsq && !hsync;
            t_ctl  = io_wr && !io_addr[15] && (io_data[7:6] == 2'b10);
            e_irq  = 0;
            if (t_tick) begin
                e_vld = 1;
                e_cnt = pix_count(m_mode);
                e_rgb = '0;
                for (int n = 0; n < e_cnt; n++) begin
                    t_code = disp_en ? m_tab[pen_of(m_mode, int'(vid_byte), n)] : m_tab[16];
                    e_rgb[n*8 +: 8] = 8'(col332(t_code));
                end
            end else begin
                e_vld = 0;
            end
            if (t_fall && m_armed) m_mode = m_pend;
            if (t_tick) m_hsq = hsync;
            if (io_wr && !io_addr[15]) begin
                case (io_data[7:6])
                    2'b00: m_sel = io_data[4] ? 16 : int'(io_data[3:0]);
                    2'b01: m_tab[m_sel] = int'(io_data[4:0]);
                    2'b10: begin
                        m_pend  = int'(io_data[1:0]);
                        m_armed = 1;
                        e_rom   = !io_data[3];
                        e_irq   = io_data[4];
                    end
                    default: ;
                endcase
            end
            if (!t_ctl && t_fall) m_armed = 0;
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(pix_vld === e_vld, "pix_vld", 64'(pix_vld), 64'(e_vld));
            chk(pix_cnt === 4'(e_cnt), "pix_cnt", 64'(pix_cnt), 64'(e_cnt));
            chk(pix_rgb === e_rgb, "pix_rgb", pix_rgb, e_rgb);
            chk(upper_rom_en === e_rom, "upper_rom_en", 64'(upper_rom_en), 64'(e_rom));
            chk(irq_cnt_clr === e_irq, "irq_cnt_clr", 64'(irq_cnt_clr), 64'(e_irq));
        end
    end

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            vb_state = (vb_state * 5 + 29) % 256;
            vid_byte = 8'(vb_state);
        end
    endtask

    task automatic run_fixed(input logic [7:0] b, input int n);
        repeat (n) begin
            @(negedge clk);
            vid_byte = b;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_data = d;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'hFFFF; io_data = 8'h00;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; io_wr = 1'b0; io_addr = 16'hFFFF; io_data = 8'h00;
        vid_byte = 8'h00; disp_en = 1'b1; hsync = 1'b0;
        cur_req = "R1";
        @(negedge clk);
        cmp_on = 1;
        repeat (3) @(negedge clk);
        chk(pix_vld === 1'b0 && pix_rgb === '0 && upper_rom_en === 1'b1, "reset outputs",
            {pix_rgb[61:0], pix_vld, upper_rom_en}, 64'h1);
        rst_n = 1'b1;

        cur_req = "R2";
        run(12);

        cur_req = "R4";
        for (int p = 0; p < 16; p++) begin
            wr(16'h7F00, {3'b000, 1'b0, 4'(p)});
            wr(16'h7F00, {3'b010, 5'((p * 5 + 3) % 32)});
        end
        wr(16'h7F00, 8'h10);
        wr(16'h7F00, {3'b010, 5'd13});
        run(8);

        cur_req = "R3";
        wr(16'h7F00, 8'h02);
        wr(16'hBF00, {3'b010, 5'd30});
        run_fixed(8'hFF, 8);
        wr(16'h3F00, {3'b010, 5'd20});
        run_fixed(8'h0C, 8);

        cur_req = "R4";
        wr(16'h7F00, 8'hC7);
        run_fixed(8'h0C, 8);

        cur_req = "R5";
        run_fixed(8'hAA, 4);
        run_fixed(8'h55, 4);
        run(40);

        cur_req = "R9";
        disp_en = 1'b0;
        run(12);
        disp_en = 1'b1;

        cur_req = "R10";
        wr(16'h7F00, 8'h81);
        run(12);
        hsync = 1'b1;
        run(8);
        hsync = 1'b0;
        run(8);

        cur_req = "R6";
        run_fixed(8'hF0, 4);
        run(32);

        cur_req = "R10";
        hsync = 1'b1;
        wr(16'h7F00, 8'h83);
        wr(16'h7F00, 8'h82);
        run(6);
        hsync = 1'b0;
        run(8);

        cur_req = "R7";
        run_fixed(8'hA5, 4);
        run(32);

        cur_req = "R5";
        wr(16'h7F00, 8'h83);
        hsync = 1'b1;
        run(8);
        hsync = 1'b0;
        run(24);

        cur_req = "R11";
        wr(16'h7F00, 8'h88);
        run(4);
        wr(16'h7F00, 8'h91);
        run(4);
        wr(16'hFF00, 8'h98);
        run(4);

        cur_req = "R8";
        hsync = 1'b1;
        run(8);
        hsync = 1'b0;
        for (int p = 0; p < 16; p++) run_fixed(8'(p * 17), 4);

        cur_req = "R12";
        run(24);

        finish_run();
    end

endmodule